// File: doc/BRIEF.md
# Indirect Register Access Controller

This block connects a processor bus with a 3-bit direct address to a large indirect register space that is spread over several channels. The processor writes a 16-bit indirect address to direct slot 3. The controller keeps that pointer. It splits the pointer into a channel nibble (bits 15:12) and a register offset (bits 11:0), and drives the decoded selects toward the channel logic. When the addressed source is flagged as needing a sample before it can be read, the controller also fires a one-cycle fetch pulse to that channel. The processor then reads the selected value as two 16-bit halves from direct slots 0 and 1.

Indirect writes use the same pointer. The processor stages the low and high data words in slots 0 and 1, and a write to slot 2 commits them to the addressed register. Because reads and writes share one pointer, a write can be checked straight away by a readback without loading the address again. Nibble F addresses every channel at once for writes, and reads through it see channel 0. A write to offset 00Fh samples the loop gain of all channels together. Reads never fetch that gain.

Top module: `idx_port_ctrl`

## Requirements
- R1: After reset, `rdata`, the pointer, `fetch_stb`, `wr_stb` and `agc_smp` are all zero. `rdata` changes only on a cycle with `bus_rd` high.
- R2: A bus write to direct slot 3 loads `bus_wdata` into the pointer. A read of slot 3 returns the pointer. `sel_chan` and `sel_ofs` show the decoded channel (nibble at bits 15:12) and the offset (bits 11:0).
- R3: Loading a pointer at offset 004h (the snapshot source, the only source flagged for fetch) with a valid nibble raises exactly one `fetch_stb` bit for the cycle after the write. Nibble F selects bit 0. The held snapshot changes only when the pointer is written again.
- R4: Pointers to sources that are not flagged (offsets 000h to 003h) raise no fetch. Repeated reads of them return the live input value without the pointer being rewritten.
- R5: Read data returns one cycle after `bus_rd`. Slot 0 returns bits 15:0 of the selected value. Slot 1 returns bits 31:16, zero-extended: format (offset 000h, 25 bits) bit 24 appears at bit 8. Offsets 001h (gain), 002h (decimation) and 003h (loop gain) read 16-bit values, and 004h reads a 24-bit snapshot.
- R6: With nibble F, reads return channel 0, and a committed write raises every `wr_stb` bit.
- R7: Nibbles 4h to Eh are invalid. They cause no fetch, write or gain-sample strobe, and slots 0 and 1 read zero.
- R8: Bus writes to slots 0 and 1 stage the low and high data words. A write to slot 2 raises `wr_stb` for the selected channel for one cycle, with `wr_val` = {high, low}. This happens only for offsets 000h to 002h; commits to any other offset raise no `wr_stb`.
- R9: A commit to offset 00Fh with a valid nibble raises `agc_smp` for one cycle and no `wr_stb`. A pointer to offset 003h reads the loop gain and never raises a fetch.
- R10: After an indirect write, a read of slots 0 and 1 without rewriting the pointer returns the newly written value.
- R11: Offsets with no mapped source read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Direct slot address |
| bus_wdata | input | 16 | Bus write data |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| fmt_in | input | NCHAN*FMT_W | Per-channel format value, offset 000h |
| gain_in | input | NCHAN*GAIN_W | Per-channel gain, offset 001h |
| dec_in | input | NCHAN*DEC_W | Per-channel decimation, offset 002h |
| agc_in | input | NCHAN*AGC_W | Per-channel sampled loop gain, offset 003h |
| snap_in | input | NCHAN*SNAP_W | Per-channel held snapshot, offset 004h |
| rdata | output | 16 | Registered read data |
| sel_ok | output | 1 | Pointer nibble is valid |
| sel_chan | output | CH_W | Decoded channel index |
| sel_ofs | output | 12 | Decoded register offset |
| fetch_stb | output | NCHAN | One-cycle fetch pulse per channel |
| wr_stb | output | NCHAN | One-cycle indirect write pulse per channel |
| wr_val | output | 32 | Staged indirect write data |
| agc_smp | output | 1 | One-cycle all-channel gain sample pulse |

## Verification
The bench goes after the following mistakes:
- A fetch pulse raised for unflagged offsets, or for the gain offset, would show up as stray `fetch_stb` bits.
- Snapshot reads that follow the live source instead of the held sample would return the changed value.
- An upper half that is sign-extended or shifted the wrong way would break the 25-bit format readback.
- Treating nibble F as invalid, or failing to broadcast on it, would change reads and `wr_stb`.
- Accepting nibbles 4h to Eh would leak data or strobes.

Random pointers over every nibble and a mix of offsets are compared against a bench model, as is a readback after a write with no pointer reload.

// File: rtl/idx_pkg.sv
package idx_pkg;

    localparam int IA_W  = 16;
    localparam int DW    = 16;
    localparam int OFS_W = 12;
    localparam int VAL_W = 32;

    localparam logic [3:0]       NIB_ALL     = 4'hF;
    localparam logic [OFS_W-1:0] OFS_FMT     = 12'h000;
    localparam logic [OFS_W-1:0] OFS_GAIN    = 12'h001;
    localparam logic [OFS_W-1:0] OFS_DEC     = 12'h002;
    localparam logic [OFS_W-1:0] OFS_AGC     = 12'h003;
    localparam logic [OFS_W-1:0] OFS_SNAP    = 12'h004;
    localparam logic [OFS_W-1:0] OFS_AGC_SMP = 12'h00F;

    localparam logic [2:0] DA_LO  = 3'd0;
    localparam logic [2:0] DA_HI  = 3'd1;
    localparam logic [2:0] DA_GO  = 3'd2;
    localparam logic [2:0] DA_PTR = 3'd3;

    typedef enum logic [2:0] {
        SRC_FMT  = 3'd0,
        SRC_GAIN = 3'd1,
        SRC_DEC  = 3'd2,
        SRC_AGC  = 3'd3,
        SRC_SNAP = 3'd4,
        SRC_NONE = 3'd5
    } src_e;

    typedef struct packed {
        logic             ok;
        logic             bcast;
        logic [3:0]       chan;
        logic [OFS_W-1:0] ofs;
    } sel_t;

    function automatic src_e src_of(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_FMT:  return SRC_FMT;
            OFS_GAIN: return SRC_GAIN;
            OFS_DEC:  return SRC_DEC;
            OFS_AGC:  return SRC_AGC;
            OFS_SNAP: return SRC_SNAP;
            default:  return SRC_NONE;
        endcase
    endfunction

    function automatic logic is_writable(input src_e s);
        return (s == SRC_FMT) || (s == SRC_GAIN) || (s == SRC_DEC);
    endfunction

    function automatic sel_t decode(input logic [IA_W-1:0] a, input int nchan);
        sel_t s;
        s.ofs   = a[OFS_W-1:0];
        s.chan  = '0;
        s.bcast = 1'b0;
        s.ok    = 1'b0;
        if (a[IA_W-1:OFS_W] == NIB_ALL) begin
            s.ok    = 1'b1;
            s.bcast = 1'b1;
        end else if (int'(a[IA_W-1:OFS_W]) < nchan) begin
            s.ok   = 1'b1;
            s.chan = a[IA_W-1:OFS_W];
        end
        return s;
    endfunction

endpackage

// File: rtl/idx_addr_reg.sv
module idx_addr_reg
    import idx_pkg::*;
#(
    parameter int NCHAN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [IA_W-1:0] din,
    output logic [IA_W-1:0] addr_q,
    output sel_t            sel
);

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else if (ld) addr_q <= din;
    end

    always_comb sel = decode(addr_q, NCHAN);

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> addr_q == $past(din));

    // R10: the pointer survives everything but a load, so readback needs no reload
    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(addr_q));

endmodule

// File: rtl/idx_strobe_gen.sv
module idx_strobe_gen
    import idx_pkg::*;
#(
    parameter int         NCHAN      = 4,
    parameter logic [5:0] FETCH_MASK = 6'b010000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_addr,
    input  logic [IA_W-1:0]  din,
    input  logic             commit,
    input  sel_t             sel,
    output logic [NCHAN-1:0] fetch_stb,
    output logic [NCHAN-1:0] wr_stb,
    output logic             agc_smp
);

    localparam logic [NCHAN-1:0] ONE = {{(NCHAN-1){1'b0}}, 1'b1};

    sel_t nsel;
    src_e nsrc;
    src_e csrc;
    logic need_fetch;
    logic do_write;
    logic do_sample;

    always_comb begin
        nsel       = decode(din, NCHAN);
        nsrc       = src_of(nsel.ofs);
        csrc       = src_of(sel.ofs);
        need_fetch = ld_addr && nsel.ok && FETCH_MASK[int'(nsrc)];
        do_write   = commit && sel.ok && is_writable(csrc);
        do_sample  = commit && sel.ok && (sel.ofs == OFS_AGC_SMP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_stb <= '0;
            wr_stb    <= '0;
            agc_smp   <= 1'b0;
        end else begin
            fetch_stb <= need_fetch ? (ONE << nsel.chan) : '0;
            if (do_write) wr_stb <= sel.bcast ? '1 : (ONE << sel.chan);
            else          wr_stb <= '0;
            agc_smp   <= do_sample;
        end
    end

    assert_fetch_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fetch_stb));

    assert_fetch_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_stb != '0) |-> $past(ld_addr));

    assert_wr_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb != '0) |-> $past(commit));

    assert_sample_alone_R9: assert property (@(posedge clk) disable iff (rst)
        agc_smp |-> (wr_stb == '0) && (fetch_stb == '0));

    assert_invalid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && !sel.ok && !ld_addr) |=> (wr_stb == '0) && !agc_smp && (fetch_stb == '0));

endmodule

// File: rtl/idx_read_mux.sv
module idx_read_mux
    import idx_pkg::*;
#(
    parameter int NCHAN  = 4,
    parameter int FMT_W  = 25,
    parameter int GAIN_W = 16,
    parameter int DEC_W  = 16,
    parameter int AGC_W  = 16,
    parameter int SNAP_W = 24,
    localparam int CH_W  = $clog2(NCHAN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd,
    input  logic [2:0]              dir_addr,
    input  logic [IA_W-1:0]         addr_q,
    input  logic                    sel_ok,
    input  logic [CH_W-1:0]         sel_idx,
    input  logic [OFS_W-1:0]        sel_ofs,
    input  logic [NCHAN*FMT_W-1:0]  fmt_in,
    input  logic [NCHAN*GAIN_W-1:0] gain_in,
    input  logic [NCHAN*DEC_W-1:0]  dec_in,
    input  logic [NCHAN*AGC_W-1:0]  agc_in,
    input  logic [NCHAN*SNAP_W-1:0] snap_in,
    output logic [DW-1:0]           rdata
);

    logic [FMT_W-1:0]  fmt_a  [NCHAN];
    logic [GAIN_W-1:0] gain_a [NCHAN];
    logic [DEC_W-1:0]  dec_a  [NCHAN];
    logic [AGC_W-1:0]  agc_a  [NCHAN];
    logic [SNAP_W-1:0] snap_a [NCHAN];

    for (genvar c = 0; c < NCHAN; c++) begin : g_unpack
        assign fmt_a[c]  = fmt_in[c*FMT_W +: FMT_W];
        assign gain_a[c] = gain_in[c*GAIN_W +: GAIN_W];
        assign dec_a[c]  = dec_in[c*DEC_W +: DEC_W];
        assign agc_a[c]  = agc_in[c*AGC_W +: AGC_W];
        assign snap_a[c] = snap_in[c*SNAP_W +: SNAP_W];
    end

    logic [VAL_W-1:0] val;

    always_comb begin
        val = '0;
        if (sel_ok) begin
            case (src_of(sel_ofs))
                SRC_FMT:  val = VAL_W'(fmt_a[sel_idx]);
                SRC_GAIN: val = VAL_W'(gain_a[sel_idx]);
                SRC_DEC:  val = VAL_W'(dec_a[sel_idx]);
                SRC_AGC:  val = VAL_W'(agc_a[sel_idx]);
                SRC_SNAP: val = VAL_W'(snap_a[sel_idx]);
                default:  val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (dir_addr)
                DA_LO:   rdata <= val[DW-1:0];
                DA_HI:   rdata <= val[VAL_W-1:DW];
                DA_PTR:  rdata <= addr_q;
                default: rdata <= '0;
            endcase
        end
    end

    assert_rd_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        (rd && dir_addr == DA_PTR) |=> rdata == $past(addr_q));

    assert_rd_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !sel_ok && (dir_addr == DA_LO || dir_addr == DA_HI)) |=> rdata == '0);

    assert_rd_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/idx_port_ctrl.sv
module idx_port_ctrl
    import idx_pkg::*;
#(
    parameter int         NCHAN      = 4,
    parameter int         FMT_W      = 25,
    parameter int         GAIN_W     = 16,
    parameter int         DEC_W      = 16,
    parameter int         AGC_W      = 16,
    parameter int         SNAP_W     = 24,
    parameter logic [5:0] FETCH_MASK = 6'b010000,
    localparam int        CH_W       = $clog2(NCHAN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [NCHAN*FMT_W-1:0]  fmt_in,
    input  logic [NCHAN*GAIN_W-1:0] gain_in,
    input  logic [NCHAN*DEC_W-1:0]  dec_in,
    input  logic [NCHAN*AGC_W-1:0]  agc_in,
    input  logic [NCHAN*SNAP_W-1:0] snap_in,
    output logic [DW-1:0]           rdata,
    output logic                    sel_ok,
    output logic [CH_W-1:0]         sel_chan,
    output logic [OFS_W-1:0]        sel_ofs,
    output logic [NCHAN-1:0]        fetch_stb,
    output logic [NCHAN-1:0]        wr_stb,
    output logic [VAL_W-1:0]        wr_val,
    output logic                    agc_smp
);

    logic            ld_addr;
    logic            commit;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   hi_q;
    logic [IA_W-1:0] addr_q;
    sel_t            sel;

    assign ld_addr = bus_wr && (bus_addr == DA_PTR);
    assign commit  = bus_wr && (bus_addr == DA_GO);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == DA_LO) lo_q <= bus_wdata;
            if (bus_addr == DA_HI) hi_q <= bus_wdata;
        end
    end

    assign wr_val   = {hi_q, lo_q};
    assign sel_ok   = sel.ok;
    assign sel_chan = sel.chan[CH_W-1:0];
    assign sel_ofs  = sel.ofs;

    idx_addr_reg #(.NCHAN(NCHAN)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_addr),
        .din    (bus_wdata),
        .addr_q (addr_q),
        .sel    (sel)
    );

    idx_strobe_gen #(.NCHAN(NCHAN), .FETCH_MASK(FETCH_MASK)) u_stb (
        .clk       (clk),
        .rst       (rst),
        .ld_addr   (ld_addr),
        .din       (bus_wdata),
        .commit    (commit),
        .sel       (sel),
        .fetch_stb (fetch_stb),
        .wr_stb    (wr_stb),
        .agc_smp   (agc_smp)
    );

    idx_read_mux #(
        .NCHAN(NCHAN), .FMT_W(FMT_W), .GAIN_W(GAIN_W),
        .DEC_W(DEC_W), .AGC_W(AGC_W), .SNAP_W(SNAP_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (bus_rd),
        .dir_addr (bus_addr),
        .addr_q   (addr_q),
        .sel_ok   (sel.ok),
        .sel_idx  (sel.chan[CH_W-1:0]),
        .sel_ofs  (sel.ofs),
        .fmt_in   (fmt_in),
        .gain_in  (gain_in),
        .dec_in   (dec_in),
        .agc_in   (agc_in),
        .snap_in  (snap_in),
        .rdata    (rdata)
    );

    // R8: staged words move only on their own slot writes
    assert_stage_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(wr_val));

endmodule

// File: tb/idx_port_ctrl_test.sv
module idx_port_ctrl_test;

    localparam int NCH = 4;
    localparam int FW = 25, GW = 16, DCW = 16, AW = 16, SW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0]        bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [NCH*FW-1:0] fmt_in;
    logic [NCH*GW-1:0] gain_in;
    logic [NCH*DCW-1:0] dec_in;
    logic [NCH*AW-1:0] agc_in;
    logic [NCH*SW-1:0] snap_in;
    logic [15:0]       rdata;
    logic              sel_ok;
    logic [1:0]        sel_chan;
    logic [11:0]       sel_ofs;
    logic [NCH-1:0]    fetch_stb, wr_stb;
    logic [31:0]       wr_val;
    logic              agc_smp;

    logic [FW-1:0]  fmt_v  [NCH];
    logic [GW-1:0]  gain_v [NCH];
    logic [DCW-1:0] dec_v  [NCH];
    logic [AW-1:0]  agc_v  [NCH];
    logic [SW-1:0]  snap_v [NCH];
    logic [SW-1:0]  live_v [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_in
        assign fmt_in[c*FW +: FW]    = fmt_v[c];
        assign gain_in[c*GW +: GW]   = gain_v[c];
        assign dec_in[c*DCW +: DCW]  = dec_v[c];
        assign agc_in[c*AW +: AW]    = agc_v[c];
        assign snap_in[c*SW +: SW]   = snap_v[c];
    end

    idx_port_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .fmt_in(fmt_in), .gain_in(gain_in),
        .dec_in(dec_in), .agc_in(agc_in), .snap_in(snap_in), .rdata(rdata),
        .sel_ok(sel_ok), .sel_chan(sel_chan), .sel_ofs(sel_ofs),
        .fetch_stb(fetch_stb), .wr_stb(wr_stb), .wr_val(wr_val), .agc_smp(agc_smp)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [NCH-1:0] st_fetch, st_wr;
    logic           st_agc;
    logic [31:0]    st_val;
    logic [11:0]    st_ofs;
    logic [15:0]    ptr = '0;
    logic [15:0]    q;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int chan_of(input logic [15:0] a);
        if (a[15:12] == 4'hF) return 0;
        if (a[15:12] < 4'd4) return int'(a[15:12]);
        return -1;
    endfunction

    function automatic logic [31:0] exp_val(input logic [15:0] a);
        int ch = chan_of(a);
        if (ch < 0) return 32'h0;
        case (a[11:0])
            12'h000: return 32'(fmt_v[ch]);
            12'h001: return 32'(gain_v[ch]);
            12'h002: return 32'(dec_v[ch]);
            12'h003: return 32'(agc_v[ch]);
            12'h004: return 32'(snap_v[ch]);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] dir, input logic [15:0] a);
        logic [31:0] v = exp_val(a);
        case (dir)
            3'd0:    return v[15:0];
            3'd1:    return v[31:16];
            3'd3:    return a;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [NCH-1:0] exp_fetch(input logic [15:0] a);
        int ch = chan_of(a);
        if (ch >= 0 && a[11:0] == 12'h004) return NCH'(1) << ch;
        return '0;
    endfunction

    task automatic do_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        st_fetch = fetch_stb;
        st_wr    = wr_stb;
        st_agc   = agc_smp;
        st_val   = wr_val;
        st_ofs   = sel_ofs;
        if (a == 3'd3) ptr = d;
        for (int c = 0; c < NCH; c++) begin
            if (st_fetch[c]) snap_v[c] = live_v[c];
            if (st_wr[c]) begin
                case (st_ofs)
                    12'h000: fmt_v[c]  = st_val[FW-1:0];
                    12'h001: gain_v[c] = st_val[15:0];
                    12'h002: dec_v[c]  = st_val[15:0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [15:0] r);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        r = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a);
        logic [15:0] r;
        do_rd(a, r);
        chk(tag, 32'(r), 32'(exp_rd(a, ptr)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired (all requirements): actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < NCH; c++) begin
            fmt_v[c] = '0; gain_v[c] = '0; dec_v[c] = '0;
            agc_v[c] = '0; snap_v[c] = '0; live_v[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 strobes", {fetch_stb, wr_stb, 3'b0, agc_smp}, 0);
        chk("R1 chan", 32'(sel_chan), 0);
        rd_chk("R1 pointer", 3'd3);

        // R2 pointer load and decode
        do_wr(3'd3, 16'h2001);
        rd_chk("R2 pointer readback", 3'd3);
        chk("R2 sel_chan", 32'(sel_chan), 2);
        chk("R2 sel_ofs", 32'(sel_ofs), 32'h001);

        // R5 halves, zero-extension of 25-bit format; R4 no fetch
        fmt_v[1] = 25'h1ABCDEF;
        do_wr(3'd3, 16'h1000);
        chk("R4 no fetch on format", 32'(st_fetch), 0);
        rd_chk("R5 low half", 3'd0);
        rd_chk("R5 high half", 3'd1);
        do_rd(3'd1, q);
        chk("R5 high literal", 32'(q), 32'h01AB);
        // R4 live data
        fmt_v[1] = 25'h0123456;
        do_rd(3'd0, q);
        chk("R4 live low", 32'(q), 32'h3456);

        // R3 strobed snapshot
        live_v[2] = 24'h123456;
        do_wr(3'd3, 16'h2004);
        chk("R3 fetch ch2", 32'(st_fetch), 32'b0100);
        live_v[2] = 24'h654321;
        do_rd(3'd0, q);
        chk("R3 held low", 32'(q), 32'h3456);
        do_rd(3'd1, q);
        chk("R3 held high", 32'(q), 32'h0012);
        do_wr(3'd3, 16'h2004);
        do_rd(3'd0, q);
        chk("R3 refetched low", 32'(q), 32'h4321);
        do_wr(3'd3, 16'hF004);
        chk("R3 bcast fetch ch0", 32'(st_fetch), 32'b0001);

        // R7 invalid nibble
        gain_v[1] = 16'hAAAA;
        do_wr(3'd3, 16'h5001);
        rd_chk("R7 invalid read", 3'd0);
        chk("R7 invalid literal", 32'(exp_rd(3'd0, 16'h5001)), 0);
        do_wr(3'd3, 16'h9004);
        chk("R7 no fetch", 32'(st_fetch), 0);
        do_wr(3'd2, 16'h0);
        chk("R7 no write", 32'(st_wr), 0);
        do_wr(3'd3, 16'hE00F);
        do_wr(3'd2, 16'h0);
        chk("R7 no sample", 32'(st_agc), 0);

        // R8 indirect write and R10 readback
        do_wr(3'd0, 16'hBEEF);
        do_wr(3'd1, 16'h0000);
        do_wr(3'd3, 16'h3001);
        do_wr(3'd2, 16'h0);
        chk("R8 wr_stb ch3", 32'(st_wr), 32'b1000);
        chk("R8 wr_val", st_val, 32'h0000BEEF);
        do_rd(3'd0, q);
        chk("R10 readback", 32'(q), 32'hBEEF);
        do_wr(3'd3, 16'h2003);
        do_wr(3'd2, 16'h0);
        chk("R8 agc offset not writable", 32'(st_wr), 0);
        do_wr(3'd3, 16'h1004);
        do_wr(3'd2, 16'h0);
        chk("R8 snapshot offset not writable", 32'(st_wr), 0);

        // R6 broadcast
        do_wr(3'd0, 16'h0777);
        do_wr(3'd3, 16'hF002);
        do_wr(3'd2, 16'h0);
        chk("R6 bcast write", 32'(st_wr), 32'b1111);
        do_rd(3'd0, q);
        chk("R6 bcast read ch0", 32'(q), 32'h0777);
        do_wr(3'd3, 16'h3002);
        do_rd(3'd0, q);
        chk("R6 bcast reached ch3", 32'(q), 32'h0777);

        // R9 gain sample and gain read
        do_wr(3'd3, 16'h100F);
        do_wr(3'd2, 16'h0);
        chk("R9 agc_smp", 32'(st_agc), 1);
        chk("R9 no wr_stb", 32'(st_wr), 0);
        agc_v[2] = 16'h5A5A;
        do_wr(3'd3, 16'h2003);
        chk("R9 no fetch for gain", 32'(st_fetch), 0);
        rd_chk("R9 gain read", 3'd0);

        // R11 unmapped offset
        do_wr(3'd3, 16'h0123);
        rd_chk("R11 unmapped low", 3'd0);
        rd_chk("R11 unmapped high", 3'd1);

        // Random pointers against the model
        for (int i = 0; i < 200; i++) begin
            logic [11:0] ofs;
            logic [15:0] a;
            for (int c = 0; c < NCH; c++) begin
                fmt_v[c]  = FW'($urandom);
                gain_v[c] = GW'($urandom);
                dec_v[c]  = DCW'($urandom);
                agc_v[c]  = AW'($urandom);
                live_v[c] = SW'($urandom);
            end
            case ($urandom % 7)
                0: ofs = 12'h000;
                1: ofs = 12'h001;
                2: ofs = 12'h002;
                3: ofs = 12'h003;
                4: ofs = 12'h004;
                5: ofs = 12'h00F;
                default: ofs = 12'($urandom);
            endcase
            a = {4'($urandom), ofs};
            do_wr(3'd3, a);
            chk("R3 R4 random fetch", 32'(st_fetch), 32'(exp_fetch(a)));
            rd_chk("R5 random low", 3'd0);
            rd_chk("R5 random high", 3'd1);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule